// File: doc/BRIEF.md
# Data-Capture Wakeup-Select Issue Queue

This block is a small reservation-station array for an out-of-order core. Each slot holds one waiting instruction: an opcode, a destination tag and two source operands, each with a producer tag, a captured value and a ready bit. Results from execution come back on several broadcast buses. Each bus carries a producer tag and its value. When a broadcast tag equals a waiting source tag, the operand becomes ready and the value is written into the slot at the same clock edge. Issue therefore needs no register-file read.

Each cycle, every valid, unissued slot whose two operands are ready asks to issue. A fixed-priority picker grants the lowest-index requester. The granted slot's opcode, destination and both operand values appear combinationally on the issue outputs. An issued slot stays in the array until an explicit per-slot free pulse releases it. New instructions enter through a dispatch port that writes the lowest-index empty slot. The port reports which slot it wrote and deasserts its ready output when the array is full.

Top module: `wakeup_select_iq`

## Requirements
- R1: Dispatch writes the lowest-index empty slot, and `disp_slot` shows that index while `disp_ready` is high. `disp_ready` is low exactly when every slot is valid. A dispatch offered while `disp_ready` is low changes nothing.
- R2: An operand dispatched with its ready flag set keeps the supplied value. A slot dispatched with both operands ready can issue in the cycle after dispatch, and the issue outputs carry its opcode and destination.
- R3: A broadcast on any bus whose tag equals a not-ready source tag of a valid slot sets that operand ready and captures the bus value at the same edge. Both operands of one slot may wake in one cycle.
- R4: When more than one bus matches the same waiting operand in one cycle, the value from the lowest-numbered bus is captured.
- R5: A broadcast in the same cycle as a dispatch wakes the new instruction's matching not-ready operands and captures the bus value.
- R6: An operand that is already ready keeps its value when a later broadcast carries a matching tag.
- R7: A slot requests issue only when it is valid, both operands are ready and it has not issued. The grant goes to the lowest-index requester, in the same cycle that the slot requests. `iss_valid` is low when no slot requests.
- R8: After issue, a slot stays valid and is never granted again until it is freed and refilled. Issue does not raise `disp_ready`.
- R9: A high bit `free_vec[i]` empties valid slot i at the edge, and that slot can be refilled from the next cycle. Freeing an empty slot has no effect.
- R10: After reset every slot is empty, `disp_ready` is high and `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least one slot is empty |
| disp_slot | output | SLOT_W | Slot that a dispatch in this cycle writes |
| disp_op | input | OP_W | Opcode of dispatched instruction |
| disp_dst | input | TAG_W | Destination tag |
| disp_l_tag | input | TAG_W | Left source producer tag |
| disp_l_rdy | input | 1 | Left value already available |
| disp_l_val | input | DATA_W | Left value when available |
| disp_r_tag | input | TAG_W | Right source producer tag |
| disp_r_rdy | input | 1 | Right value already available |
| disp_r_val | input | DATA_W | Right value when available |
| bc_valid | input | NBUS | Per-bus broadcast valid |
| bc_tag | input | NBUS*TAG_W | Broadcast tags, bus b at bits [b*TAG_W +: TAG_W] |
| bc_val | input | NBUS*DATA_W | Broadcast values, bus b at bits [b*DATA_W +: DATA_W] |
| free_vec | input | ENTRIES | Per-slot release |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_slot | output | SLOT_W | Slot being issued |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_l_val | output | DATA_W | Issued left operand value |
| iss_r_val | output | DATA_W | Issued right operand value |

## Verification
The assertions check several properties on every cycle. The picker never grants more than one slot and grants only a slot that requests. A ready operand keeps its value while the slot is not rewritten. A woken operand is ready on the next cycle. A granted slot stops requesting after its grant. A dispatch refused while the array is full leaves the slot occupancy unchanged. Some behaviours can be shown only by the bench's scenarios, run against its cycle-level model. These are the lowest-bus choice when buses collide, the wakeup of an instruction in its own dispatch cycle, the exact values delivered on issue, and slot reuse after a free.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_ENTRIES = 8;
  localparam int unsigned IQ_NBUS    = 2;
  localparam int unsigned IQ_TAG_W   = 6;
  localparam int unsigned IQ_DATA_W  = 16;
  localparam int unsigned IQ_OP_W    = 4;

  // One-hot to binary index; zero when the vector is empty.
  function automatic int unsigned onehot_index(input logic [63:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < 64; i++)
      if (i < n && v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/iq_picker.sv
module iq_picker #(
  parameter int unsigned N   = iq_pkg::IQ_ENTRIES,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | req[i];
    assign grant[i]     = req[i] & ~blocked[i];
  end

  logic [63:0] grant_w;
  always_comb begin
    grant_w = '0;
    grant_w[N-1:0] = grant;
  end

  assign any = blocked[N];
  assign idx = IDX_W'(iq_pkg::onehot_index(grant_w, N));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R7
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~req) == '0));
  // R7
  any_means_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> $countones(grant) == 1);
endmodule

// File: rtl/iq_operand.sv
module iq_operand #(
  parameter int unsigned NBUS   = iq_pkg::IQ_NBUS,
  parameter int unsigned TAG_W  = iq_pkg::IQ_TAG_W,
  parameter int unsigned DATA_W = iq_pkg::IQ_DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   live,
  input  logic                   wr_en,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   wr_rdy,
  input  logic [DATA_W-1:0]      wr_val,
  input  logic [NBUS-1:0]        bc_valid,
  input  logic [NBUS*TAG_W-1:0]  bc_tag,
  input  logic [NBUS*DATA_W-1:0] bc_val,
  output logic                   rdy_o,
  output logic [DATA_W-1:0]      val_o,
  output logic                   woke_o
);
  logic [TAG_W-1:0]  tag_q;
  logic              rdy_q;
  logic [DATA_W-1:0] val_q;
  logic [TAG_W-1:0]  cmp_tag;
  logic              hit;
  logic [DATA_W-1:0] hit_val;

  assign cmp_tag = wr_en ? wr_tag : tag_q;

  // Lowest-numbered matching bus wins: scan downward so it is written last.
  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int b = NBUS - 1; b >= 0; b--) begin
      if (bc_valid[b] && bc_tag[b*TAG_W +: TAG_W] == cmp_tag) begin
        hit     = 1'b1;
        hit_val = bc_val[b*DATA_W +: DATA_W];
      end
    end
  end

  assign woke_o = !wr_en && live && !rdy_q && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      rdy_q <= 1'b0;
      val_q <= '0;
    end else if (wr_en) begin
      tag_q <= wr_tag;
      if (wr_rdy) begin
        rdy_q <= 1'b1;
        val_q <= wr_val;
      end else begin
        rdy_q <= hit;
        val_q <= hit ? hit_val : '0;
      end
    end else if (woke_o) begin
      rdy_q <= 1'b1;
      val_q <= hit_val;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  // R6
  ready_value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_q && !wr_en) |=> (rdy_q && $stable(val_q)));
  // R3
  wake_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    woke_o |=> rdy_q);
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
  parameter int unsigned NBUS   = iq_pkg::IQ_NBUS,
  parameter int unsigned TAG_W  = iq_pkg::IQ_TAG_W,
  parameter int unsigned DATA_W = iq_pkg::IQ_DATA_W,
  parameter int unsigned OP_W   = iq_pkg::IQ_OP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   free,
  input  logic                   grant,
  input  logic [OP_W-1:0]        wr_op,
  input  logic [TAG_W-1:0]       wr_dst,
  input  logic [TAG_W-1:0]       wr_l_tag,
  input  logic                   wr_l_rdy,
  input  logic [DATA_W-1:0]      wr_l_val,
  input  logic [TAG_W-1:0]       wr_r_tag,
  input  logic                   wr_r_rdy,
  input  logic [DATA_W-1:0]      wr_r_val,
  input  logic [NBUS-1:0]        bc_valid,
  input  logic [NBUS*TAG_W-1:0]  bc_tag,
  input  logic [NBUS*DATA_W-1:0] bc_val,
  output logic                   valid_o,
  output logic                   bid_o,
  output logic [OP_W-1:0]        op_o,
  output logic [TAG_W-1:0]       dst_o,
  output logic [DATA_W-1:0]      l_val_o,
  output logic [DATA_W-1:0]      r_val_o
);
  logic            valid_q, issued_q;
  logic [OP_W-1:0] op_q;
  logic [TAG_W-1:0] dst_q;
  logic            l_rdy, r_rdy, l_woke, r_woke;

  iq_operand #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_left (
    .clk, .rst_n, .live(valid_q), .wr_en,
    .wr_tag(wr_l_tag), .wr_rdy(wr_l_rdy), .wr_val(wr_l_val),
    .bc_valid, .bc_tag, .bc_val,
    .rdy_o(l_rdy), .val_o(l_val_o), .woke_o(l_woke)
  );

  iq_operand #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_right (
    .clk, .rst_n, .live(valid_q), .wr_en,
    .wr_tag(wr_r_tag), .wr_rdy(wr_r_rdy), .wr_val(wr_r_val),
    .bc_valid, .bc_tag, .bc_val,
    .rdy_o(r_rdy), .val_o(r_val_o), .woke_o(r_woke)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
      op_q     <= '0;
      dst_q    <= '0;
    end else if (wr_en) begin
      valid_q  <= 1'b1;
      issued_q <= 1'b0;
      op_q     <= wr_op;
      dst_q    <= wr_dst;
    end else begin
      if (free)  valid_q  <= 1'b0;
      if (grant) issued_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign bid_o   = valid_q && !issued_q && l_rdy && r_rdy;
  assign op_o    = op_q;
  assign dst_o   = dst_q;

  // R8
  issued_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !free && !wr_en) |=> (valid_q && !bid_o));
  // R9
  free_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free && !wr_en) |=> !valid_q);
  // R3
  wake_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_woke && r_woke) |=> (l_rdy && r_rdy));
endmodule

// File: rtl/wakeup_select_iq.sv
module wakeup_select_iq #(
  parameter int unsigned ENTRIES = iq_pkg::IQ_ENTRIES,
  parameter int unsigned NBUS    = iq_pkg::IQ_NBUS,
  parameter int unsigned TAG_W   = iq_pkg::IQ_TAG_W,
  parameter int unsigned DATA_W  = iq_pkg::IQ_DATA_W,
  parameter int unsigned OP_W    = iq_pkg::IQ_OP_W,
  localparam int unsigned SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  output logic [SLOT_W-1:0]      disp_slot,
  input  logic [OP_W-1:0]        disp_op,
  input  logic [TAG_W-1:0]       disp_dst,
  input  logic [TAG_W-1:0]       disp_l_tag,
  input  logic                   disp_l_rdy,
  input  logic [DATA_W-1:0]      disp_l_val,
  input  logic [TAG_W-1:0]       disp_r_tag,
  input  logic                   disp_r_rdy,
  input  logic [DATA_W-1:0]      disp_r_val,
  input  logic [NBUS-1:0]        bc_valid,
  input  logic [NBUS*TAG_W-1:0]  bc_tag,
  input  logic [NBUS*DATA_W-1:0] bc_val,
  input  logic [ENTRIES-1:0]     free_vec,
  output logic                   iss_valid,
  output logic [SLOT_W-1:0]      iss_slot,
  output logic [OP_W-1:0]        iss_op,
  output logic [TAG_W-1:0]       iss_dst,
  output logic [DATA_W-1:0]      iss_l_val,
  output logic [DATA_W-1:0]      iss_r_val
);
  logic [ENTRIES-1:0] valid_vec, bid_vec, grant_vec, empty_vec, alloc_vec, wr_vec;
  logic [OP_W-1:0]    op_a  [ENTRIES];
  logic [TAG_W-1:0]   dst_a [ENTRIES];
  logic [DATA_W-1:0]  lv_a  [ENTRIES];
  logic [DATA_W-1:0]  rv_a  [ENTRIES];
  logic               alloc_any;

  assign empty_vec = ~valid_vec;

  // Slot allocator: same fixed-priority picker applied to empty slots.
  iq_picker #(.N(ENTRIES)) i_alloc (
    .clk, .rst_n, .req(empty_vec), .grant(alloc_vec), .any(alloc_any), .idx(disp_slot)
  );

  // Issue select.
  iq_picker #(.N(ENTRIES)) i_select (
    .clk, .rst_n, .req(bid_vec), .grant(grant_vec), .any(iss_valid), .idx(iss_slot)
  );

  assign disp_ready = alloc_any;
  assign wr_vec     = disp_valid ? alloc_vec : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    iq_entry #(.NBUS(NBUS), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_entry (
      .clk, .rst_n,
      .wr_en(wr_vec[i]), .free(free_vec[i]), .grant(grant_vec[i]),
      .wr_op(disp_op), .wr_dst(disp_dst),
      .wr_l_tag(disp_l_tag), .wr_l_rdy(disp_l_rdy), .wr_l_val(disp_l_val),
      .wr_r_tag(disp_r_tag), .wr_r_rdy(disp_r_rdy), .wr_r_val(disp_r_val),
      .bc_valid, .bc_tag, .bc_val,
      .valid_o(valid_vec[i]), .bid_o(bid_vec[i]),
      .op_o(op_a[i]), .dst_o(dst_a[i]), .l_val_o(lv_a[i]), .r_val_o(rv_a[i])
    );
  end

  always_comb begin
    iss_op    = '0;
    iss_dst   = '0;
    iss_l_val = '0;
    iss_r_val = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) begin
        iss_op    = iss_op    | op_a[i];
        iss_dst   = iss_dst   | dst_a[i];
        iss_l_val = iss_l_val | lv_a[i];
        iss_r_val = iss_r_val | rv_a[i];
      end
    end
  end

  // R1
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready && free_vec == '0) |=> $stable(valid_vec));
  // R1
  dispatch_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && (free_vec & alloc_vec) == '0) |=> ((valid_vec & $past(alloc_vec)) != '0));
  // R8
  issue_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !disp_valid && free_vec == '0) |=> !disp_ready);
endmodule

// File: tb/test_wakeup_select_iq.sv
module test_wakeup_select_iq;
  localparam int E = 8, NB = 2, TW = 6, DW = 16, OW = 4, SW = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic disp_valid, disp_ready, disp_l_rdy, disp_r_rdy;
  logic [SW-1:0] disp_slot, iss_slot;
  logic [OW-1:0] disp_op, iss_op;
  logic [TW-1:0] disp_dst, disp_l_tag, disp_r_tag, iss_dst;
  logic [DW-1:0] disp_l_val, disp_r_val, iss_l_val, iss_r_val;
  logic [NB-1:0] bc_valid;
  logic [NB*TW-1:0] bc_tag;
  logic [NB*DW-1:0] bc_val;
  logic [E-1:0] free_vec;
  logic iss_valid;

  wakeup_select_iq i_wakeup_select_iq (.*);

  int checks = 0, fails = 0, cyc = 0;
  string phase = "R10";

  // Behavioural reference state.
  int mv[E], mis[E], mlr[E], mrr[E], mlt[E], mrt[E], mlv[E], mrv[E], mop[E], mdst[E];

  function automatic int m_grant();
    for (int i = 0; i < E; i++)
      if (mv[i] != 0 && mis[i] == 0 && mlr[i] != 0 && mrr[i] != 0) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < E; i++) if (mv[i] == 0) return i;
    return -1;
  endfunction

  function automatic int bus_hit(input int tag, output int val);
    for (int b = 0; b < NB; b++)
      if (bc_valid[b] && int'(bc_tag[b*TW +: TW]) == tag) begin
        val = int'(bc_val[b*DW +: DW]);
        return 1;
      end
    val = 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < E; i++) begin
        mv[i] = 0; mis[i] = 0; mlr[i] = 0; mrr[i] = 0;
      end
    end else begin
      int g, f, v;
      g = m_grant();
      f = m_free();
      for (int i = 0; i < E; i++) begin
        if (mv[i] != 0) begin
          if (mlr[i] == 0 && bus_hit(mlt[i], v) != 0) begin mlr[i] = 1; mlv[i] = v; end
          if (mrr[i] == 0 && bus_hit(mrt[i], v) != 0) begin mrr[i] = 1; mrv[i] = v; end
        end
        if (i == g) mis[i] = 1;
        if (free_vec[i]) mv[i] = 0;
      end
      if (disp_valid && f >= 0) begin
        mv[f] = 1; mis[f] = 0; mop[f] = disp_op; mdst[f] = disp_dst;
        mlt[f] = disp_l_tag; mrt[f] = disp_r_tag;
        if (disp_l_rdy) begin mlr[f] = 1; mlv[f] = disp_l_val; end
        else begin mlr[f] = bus_hit(mlt[f], v); mlv[f] = v; end
        if (disp_r_rdy) begin mrr[f] = 1; mrv[f] = disp_r_val; end
        else begin mrr[f] = bus_hit(mrt[f], v); mrv[f] = v; end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  // Compare on every falling edge; outputs depend only on registered state.
  always @(negedge clk) begin
    if (rst_n) begin
      int g, f;
      g = m_grant();
      f = m_free();
      chk("disp_ready", int'(disp_ready), (f >= 0) ? 1 : 0);
      if (f >= 0) chk("disp_slot", int'(disp_slot), f);
      chk("iss_valid", int'(iss_valid), (g >= 0) ? 1 : 0);
      if (g >= 0) begin
        chk("iss_slot", int'(iss_slot), g);
        chk("iss_op", int'(iss_op), mop[g]);
        chk("iss_dst", int'(iss_dst), mdst[g]);
        chk("iss_l_val", int'(iss_l_val), mlv[g]);
        chk("iss_r_val", int'(iss_r_val), mrv[g]);
      end
    end
  end

  task automatic idle_inputs();
    disp_valid = 0; disp_op = 0; disp_dst = 0;
    disp_l_tag = 0; disp_l_rdy = 0; disp_l_val = 0;
    disp_r_tag = 0; disp_r_rdy = 0; disp_r_val = 0;
    bc_valid = 0; bc_tag = 0; bc_val = 0; free_vec = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic dispatch(input int op, input int dst, input int lt, input int lr, input int lv,
                          input int rt, input int rr, input int rv);
    disp_valid = 1; disp_op = OW'(op); disp_dst = TW'(dst);
    disp_l_tag = TW'(lt); disp_l_rdy = (lr != 0); disp_l_val = DW'(lv);
    disp_r_tag = TW'(rt); disp_r_rdy = (rr != 0); disp_r_val = DW'(rv);
  endtask

  task automatic bcast(input int bus, input int tag, input int val);
    bc_valid[bus] = 1'b1;
    bc_tag[bus*TW +: TW] = TW'(tag);
    bc_val[bus*DW +: DW] = DW'(val);
  endtask

  task automatic free_all();
    free_vec = '1;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    phase = "R10";
    chk("reset disp_ready", int'(disp_ready), 1);
    chk("reset iss_valid", int'(iss_valid), 0);
    #1;

    phase = "R2";
    dispatch(3, 20, 1, 1, 111, 2, 1, 222); tick();
    tick(); tick(); free_all();

    phase = "R3";
    dispatch(5, 21, 5, 0, 0, 6, 0, 0); tick();
    bcast(0, 5, 1005); tick();
    bcast(1, 6, 1006); tick();
    tick(); tick();
    dispatch(6, 22, 7, 0, 0, 7, 0, 0); tick();
    bcast(1, 7, 777); tick(); tick(); free_all();

    phase = "R4";
    dispatch(7, 23, 9, 0, 0, 9, 0, 0); tick();
    bcast(0, 9, 900); bcast(1, 9, 901); tick(); tick(); free_all();

    phase = "R5";
    dispatch(8, 24, 11, 0, 0, 12, 1, 55); bcast(1, 11, 1111); tick(); tick(); tick(); free_all();

    phase = "R6";
    dispatch(9, 25, 12, 1, 44, 13, 0, 0); tick();
    bcast(0, 12, 4444); tick();
    bcast(0, 13, 1313); tick(); tick(); free_all();

    phase = "R1";
    for (int i = 0; i < E; i++) begin dispatch(i, i, 40, 0, 0, 41, 0, 0); tick(); end
    dispatch(15, 63, 1, 1, 9, 1, 1, 9); tick(); tick();

    phase = "R9";
    free_vec[3] = 1'b1; free_vec[5] = 1'b1; tick();
    free_vec[3] = 1'b1; tick();
    dispatch(2, 30, 1, 1, 31, 1, 1, 32); tick();
    dispatch(2, 33, 1, 1, 34, 1, 1, 35); tick(); tick();

    phase = "R8";
    bcast(0, 40, 400); bcast(1, 41, 410); tick();
    for (int i = 0; i < 10; i++) tick();
    free_all();

    phase = "R7";
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 3) != 0)
        dispatch($urandom % 16, $urandom % 64, $urandom % 12, $urandom % 2, $urandom % 65536,
                 $urandom % 12, $urandom % 2, $urandom % 65536);
      for (int b = 0; b < NB; b++)
        if (($urandom % 2) != 0) bcast(b, $urandom % 12, $urandom % 65536);
      for (int i = 0; i < E; i++)
        if (($urandom % 6) == 0) free_vec[i] = 1'b1;
      tick();
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule